// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block holds received characters for the host on the receive side of a serial port that runs with its queue enabled. Bytes from the deserializer enter through a valid strobe and a line break enters as a separate event. The host pops bytes one at a time and reads a status view made of the data-ready, break and overrun flags. A programmable fill threshold produces a level signal for the interrupt logic.

A character-time counter tracks how long data has sat unread. The counter is loaded with four frame lengths, measured in bit-period ticks, on every arrival and on every pop that leaves data behind. When it expires while bytes remain, a timeout-pending flag is raised. The frame length is derived from the word length, parity and stop-bit settings. The host programs the block through a single queue-control write whose enable and reset bits flush the queue.

Top module: `uart_rxq`

## Requirements
- R1: After reset the count, data-ready, break, overrun, timeout-pending, threshold output and control register are all zero, and the read data is 0x00.
- R2: The queue holds 16 bytes and returns them in arrival order. `rd_data_o` shows the oldest byte, `rd_i` removes it, and with the queue empty the read data is 0x00.
- R3: A byte or break that arrives while 16 bytes are held is discarded and the stored bytes stay intact. The count stays at 16 and the overrun flag is set.
- R4: Control bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. `trig_o` is high exactly while the count is at or above the threshold.
- R5: A break event stores a 0x00 byte and sets both the break flag and data-ready.
- R6: Every stored byte sets data-ready. A pop that empties the queue clears both data-ready and break, while a pop that leaves data clears neither.
- R7: A line-status read strobe clears break and overrun and leaves data-ready and the count unchanged.
- R8: The control register keeps only bits 7, 6, 3 and 0. Bit 1 written as 1 flushes the queue, and a write that changes bit 0 also flushes it. A write that leaves bit 0 unchanged and has bit 1 at 0 keeps the stored data. The overrun flag survives a flush.
- R9: The frame length in ticks is 1 + (5 + `word_len_i`) + `parity_en_i` + (`two_stop_i` ? 2 : 1). Timeout-pending rises on the 4×frame-th `bit_tick_i` after the last arrival, but only if the queue still holds data then.
- R10: Any `rd_i` clears timeout-pending. A pop that leaves data restarts the full four-frame wait. A flush clears timeout-pending and cancels the running wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Line break event |
| fcr_we_i | input | 1 | Queue-control write strobe |
| fcr_wdata_i | input | 8 | Queue-control write value |
| fcr_o | output | 8 | Retained queue-control bits |
| word_len_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Parity bit present in frame |
| two_stop_i | input | 1 | Two stop bits |
| bit_tick_i | input | 1 | One pulse per bit period |
| rd_i | input | 1 | Host pop strobe |
| lsr_rd_i | input | 1 | Line-status read strobe |
| rd_data_o | output | 8 | Oldest held byte |
| count_o | output | 5 | Bytes held |
| trig_o | output | 1 | Count at or above threshold |
| data_ready_o | output | 1 | Data-ready flag |
| break_o | output | 1 | Break flag |
| overrun_o | output | 1 | Overrun flag |
| timeout_o | output | 1 | Timeout pending |

## Verification
A corrupted pointer or count shows at the ports on the very next pop, as a byte out of order or a wrong `count_o`. It also shows as a `trig_o` edge at the wrong fill level during a fill sweep over every threshold code. A countdown that loads the wrong length or misses a restart moves the rise of `timeout_o` by a whole number of ticks. The bench measures that rise to the exact cycle for each of the sixteen frame formats. Flag state that is left stale appears the cycle after the strobe meant to clear it.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam logic [7:0] FCR_KEEP = 8'hC9;
  localparam int FCR_EN    = 0;
  localparam int FCR_RXRST = 1;
  localparam int MAX_FRAME = 12;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic int trig_level(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) wptr_q <= wptr_q + 1'b1;
      if (rd_i) rptr_q <= rptr_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = (cnt_q == '0) ? '0 : mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxq_frame_timer.sv
module rxq_frame_timer #(
  parameter int TW = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic       tick_i,
  input  logic [1:0] word_len_i,
  input  logic       parity_en_i,
  input  logic       two_stop_i,
  output logic       expire_o
);
  logic [3:0]    frame_len;
  logic [TW-1:0] load_val, left_q;
  logic          armed_q;

  // start + data + parity + stop
  assign frame_len = 4'd7 + {2'b00, word_len_i} + {3'b000, parity_en_i} + {3'b000, two_stop_i};
  assign load_val  = TW'({frame_len, 2'b00});
  assign expire_o  = armed_q && tick_i && (left_q == TW'(1)) && !clr_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      left_q  <= load_val;
    end else if (armed_q && tick_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == TW'(1)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int TW   = $clog2(4 * MAX_FRAME + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_break_i,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_wdata_i,
  output logic [7:0]    fcr_o,
  input  logic [1:0]    word_len_i,
  input  logic          parity_en_i,
  input  logic          two_stop_i,
  input  logic          bit_tick_i,
  input  logic          rd_i,
  input  logic          lsr_rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          trig_o,
  output logic          data_ready_o,
  output logic          break_o,
  output logic          overrun_o,
  output logic          timeout_o
);
  logic [7:0]    fcr_q;
  logic          rx_flush, arrive, full, wr, drop, pop, last_pop, reload, expire;
  logic          dr_q, brk_q, ovr_q, to_q;
  logic [DW-1:0] wdata;
  logic [CW-1:0] cnt;

  assign rx_flush = fcr_we_i && (fcr_wdata_i[FCR_RXRST] || (fcr_wdata_i[FCR_EN] != fcr_q[FCR_EN]));
  assign arrive   = (rx_valid_i || rx_break_i) && !rx_flush;
  assign full     = (cnt == CW'(DEPTH));
  assign wr       = arrive && !full;
  assign drop     = arrive && full;
  assign wdata    = rx_break_i ? '0 : rx_data_i;   // break wins over a data strobe
  assign pop      = rd_i && (cnt != '0) && !rx_flush;
  assign last_pop = pop && (cnt == CW'(1)) && !wr;
  assign reload   = wr || (pop && !last_pop);

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_flush),
    .wr_i    (wr),
    .wdata_i (wdata),
    .rd_i    (pop),
    .rdata_o (rd_data_o),
    .count_o (cnt)
  );

  rxq_frame_timer #(.TW(TW)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_flush),
    .load_i      (reload),
    .tick_i      (bit_tick_i),
    .word_len_i  (word_len_i),
    .parity_en_i (parity_en_i),
    .two_stop_i  (two_stop_i),
    .expire_o    (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q <= '0;
      dr_q  <= 1'b0;
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (fcr_we_i) fcr_q <= fcr_wdata_i & FCR_KEEP;

      if (rx_flush)      dr_q <= 1'b0;
      else if (arrive)   dr_q <= 1'b1;
      else if (last_pop) dr_q <= 1'b0;

      if (rx_flush)                  brk_q <= 1'b0;
      else if (rx_break_i)           brk_q <= 1'b1;
      else if (lsr_rd_i || last_pop) brk_q <= 1'b0;

      // overrun survives a flush
      if (drop)          ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;

      if (rx_flush || rd_i)           to_q <= 1'b0;
      else if (expire && cnt != '0)   to_q <= 1'b1;
    end
  end

  assign fcr_o        = fcr_q;
  assign count_o      = cnt;
  assign trig_o       = 32'(cnt) >= trig_level(fcr_q[7:6]);
  assign data_ready_o = dr_q;
  assign break_o      = brk_q;
  assign overrun_o    = ovr_q;
  assign timeout_o    = to_q;
endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          rx_break_i,
  input logic          fcr_we_i,
  input logic [7:0]    fcr_o,
  input logic          rd_i,
  input logic          lsr_rd_i,
  input logic [CW-1:0] count_o,
  input logic          data_ready_o,
  input logic          break_o,
  input logic          overrun_o,
  input logic          timeout_o
);
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !fcr_we_i && !rd_i && count_o == CW'(DEPTH))
    |=> (overrun_o && count_o == CW'(DEPTH)));

  assert_break_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_i && !fcr_we_i) |=> (break_o && data_ready_o));

  assert_lsr_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rx_valid_i && !rx_break_i) |=> (!break_o && !overrun_o));

  assert_fcr_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o & 8'h36) == 8'h00);

  assert_timeout_nonempty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (count_o != '0));

  assert_read_clears_to_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);
endmodule

bind uart_rxq uart_rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_break_i   (rx_break_i),
  .fcr_we_i     (fcr_we_i),
  .fcr_o        (fcr_o),
  .rd_i         (rd_i),
  .lsr_rd_i     (lsr_rd_i),
  .count_o      (count_o),
  .data_ready_o (data_ready_o),
  .break_o      (break_o),
  .overrun_o    (overrun_o),
  .timeout_o    (timeout_o)
);

// File: tb/uart_rxq_test.sv
module uart_rxq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_break_i = 1'b0;
  logic       fcr_we_i = 1'b0;
  logic [7:0] fcr_wdata_i = '0;
  logic [7:0] fcr_o;
  logic [1:0] word_len_i = 2'd3;
  logic       parity_en_i = 1'b0;
  logic       two_stop_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       lsr_rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [4:0] count_o;
  logic       trig_o, data_ready_o, break_o, overrun_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  uart_rxq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_break_i(rx_break_i), .fcr_we_i(fcr_we_i), .fcr_wdata_i(fcr_wdata_i), .fcr_o(fcr_o),
    .word_len_i(word_len_i), .parity_en_i(parity_en_i), .two_stop_i(two_stop_i),
    .bit_tick_i(bit_tick_i), .rd_i(rd_i), .lsr_rd_i(lsr_rd_i), .rd_data_o(rd_data_o),
    .count_o(count_o), .trig_o(trig_o), .data_ready_o(data_ready_o), .break_o(break_o),
    .overrun_o(overrun_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] b);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic brk();
    rx_break_i = 1'b1;
    @(negedge clk_i);
    rx_break_i = 1'b0;
  endtask

  task automatic pop_b(output logic [7:0] b);
    rd_i = 1'b1; b = rd_data_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic lsr_rd();
    lsr_rd_i = 1'b1;
    @(negedge clk_i);
    lsr_rd_i = 1'b0;
  endtask

  task automatic fcr_w(input logic [7:0] v);
    fcr_we_i = 1'b1; fcr_wdata_i = v;
    @(negedge clk_i);
    fcr_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic int lvl(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, all R unverified");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 data_ready", data_ready_o, 0);
    chk("R1 break", break_o, 0);
    chk("R1 overrun", overrun_o, 0);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 fcr", fcr_o, 0);
    chk("R1 rd_data", rd_data_o, 0);
    chk("R1 trig", trig_o, 0);

    // R4 / R2 sweep over all threshold codes, full fill and drain
    for (int code = 0; code < 4; code++) begin
      fcr_w(8'((code << 6) | 3));
      chk("R8 flush count", count_o, 0);
      for (int i = 1; i <= 16; i++) begin
        push_b(8'(i * 7 + code));
        chk("R4 trig level", trig_o, int'(i >= lvl(code)));
        chk("R6 data_ready on push", data_ready_o, 1);
      end
      chk("R2 full count", count_o, 16);
      if (code == 3) begin
        push_b(8'hAA);
        chk("R3 count held", count_o, 16);
        chk("R3 overrun set", overrun_o, 1);
      end
      for (int i = 1; i <= 16; i++) begin
        pop_b(b);
        chk("R2 order", b, (i * 7 + code) & 8'hFF);
        chk("R2 count after pop", count_o, 16 - i);
      end
      chk("R6 data_ready cleared", data_ready_o, 0);
      pop_b(b);
      chk("R2 empty read", b, 0);
    end
    // R8 overrun survives flush, R7 line-status read clears it
    fcr_w(8'hC3);
    chk("R8 overrun kept on flush", overrun_o, 1);
    lsr_rd();
    chk("R7 overrun cleared", overrun_o, 0);

    // R5 break
    fcr_w(8'h03);
    brk();
    chk("R5 count", count_o, 1);
    chk("R5 data_ready", data_ready_o, 1);
    chk("R5 break", break_o, 1);
    chk("R5 zero byte", rd_data_o, 0);
    lsr_rd();
    chk("R7 break cleared", break_o, 0);
    chk("R7 data_ready kept", data_ready_o, 1);
    chk("R7 count kept", count_o, 1);
    brk();
    pop_b(b);
    chk("R6 break kept on partial pop", break_o, 1);
    chk("R5 byte zero", b, 0);
    pop_b(b);
    chk("R6 break cleared on empty", break_o, 0);
    chk("R6 dr cleared on empty", data_ready_o, 0);

    // R8 control register behaviour
    fcr_w(8'hFF);
    chk("R8 kept bits", fcr_o, 8'hC9);
    push_b(8'h11);
    push_b(8'h22);
    fcr_w(8'hC1);
    chk("R8 no flush same enable", count_o, 2);
    chk("R8 kept bits 2", fcr_o, 8'hC1);
    fcr_w(8'hC0);
    chk("R8 flush on enable toggle", count_o, 0);
    push_b(8'h33);
    fcr_w(8'h01);
    chk("R8 flush on enable toggle back", count_o, 0);

    // R9 timeout over every frame format
    bit_tick_i = 1'b1;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++) begin
          int f;
          word_len_i = 2'(d); parity_en_i = 1'(p); two_stop_i = 1'(s);
          f = 1 + 5 + d + p + (s ? 2 : 1);
          fcr_w(8'h03);
          push_b(8'h5A);
          idle(4 * f - 1);
          chk("R9 timeout early", timeout_o, 0);
          idle(1);
          chk("R9 timeout at expiry", timeout_o, 1);
          pop_b(b);
          chk("R10 read clears timeout", timeout_o, 0);
          chk("R9 byte", b, 8'h5A);
        end

    // R10 restart on partial pop
    word_len_i = 2'd3; parity_en_i = 1'b0; two_stop_i = 1'b0;
    push_b(8'hA1);
    push_b(8'hB2);
    idle(20);
    pop_b(b);
    idle(39);
    chk("R10 restart early", timeout_o, 0);
    idle(1);
    chk("R10 restart expiry", timeout_o, 1);
    pop_b(b);
    chk("R10 read clears", timeout_o, 0);
    idle(50);
    chk("R9 no timeout when empty", timeout_o, 0);

    // R10 flush cancels
    push_b(8'hC4);
    idle(10);
    fcr_w(8'h03);
    idle(60);
    chk("R10 flush cancels", timeout_o, 0);
    chk("R10 flush empties", count_o, 0);

    // R9 emptied before expiry
    push_b(8'hD5);
    idle(5);
    pop_b(b);
    idle(50);
    chk("R9 emptied before expiry", timeout_o, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule